// File: doc/BRIEF.md
# DDR3 Read-Return Latency Tracker

This block sits on the controller side of a DDR3 memory interface. Every clock it samples the command pins that the controller drives to the memory: chip select, the three command strobes, the bank address and the address bus. From these it keeps a copy of the latency settings held in the memory's mode registers. For each read it tells the read-capture logic in which clock cycles the returning burst will arrive.

A read's return delay is taken from the additive latency and the CAS latency. When the mode registers switch off the memory's DLL, the return point moves one cycle earlier. In that mode only one latency setting is legal, and the block raises an error flag whenever a different setting has been programmed. The return stream is a valid-only interface with no ready signal, because memory data cannot be held back. A consumer must accept every cycle in which `rd_valid` is high. Each valid cycle carries two beats, so an eight-beat burst takes four clocks.

Top module: `rd_return_tracker`

## Requirements
- R1: Commands are decoded from (cs_n, ras_n, cas_n, we_n). Read is 0,1,0,1. Mode-register write is 0,0,0,0. No-operation is 0,1,1,1. Any cycle with cs_n = 1 is a deselect. All other patterns start nothing.
- R2: A no-operation cycle starts no read and changes no mode setting. Reads already in flight return unchanged.
- R3: In a deselect cycle the strobes, bank and address are ignored, even when they form a read or a mode-register write. Reads in flight continue.
- R4: A mode-register write with ba = 1 copies addr[0] into the DLL-off mode. The `dll_off` output shows the new value in the cycle after the command's clock edge.
- R5: Field layout. With ba = 0, CL = addr[6:4] + 4. With ba = 2, CWL = addr[5:3] + 5. With ba = 1, addr[4:3] selects AL: 0 gives 0, 1 gives CL−1, 2 gives CL−2, 3 gives 0. A mode-register write with ba of 3 or more changes nothing.
- R6: With the DLL on, a read sampled at clock edge k puts `rd_valid` high with beat 0 in the cycle that follows edge k + AL + CL.
- R7: With the DLL off, the same point is edge k + AL + CL − 1. For example, CL = 6 and AL = 0 gives 5.
- R8: A burst spans four consecutive valid cycles with `rd_beat` = 0, 2, 4, 6. Each cycle carries beats rd_beat and rd_beat+1. `rd_valid` then drops unless another burst follows.
- R9: Two reads issued four cycles apart with the same latency return as eight back-to-back valid cycles, with no gap between the bursts.
- R10: `cfg_err` is high exactly when the DLL is off and either CL ≠ 6 or CWL ≠ 6. It updates in the same cycle as `dll_off`.
- R11: Reset state: AL = 0, CL = 6, CWL = 6, DLL on, no reads pending. Outputs are `rd_valid` = 0, `rd_beat` = 0, `cfg_err` = 0, `dll_off` = 0.
- R12: A read's latency is fixed when the read is issued. A later mode-register write applies only to reads issued after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock, same as the memory command clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe |
| cas_n | input | 1 | Column strobe |
| we_n | input | 1 | Write-enable strobe |
| ba | input | 3 | Bank address; selects the mode register on a mode-register write |
| addr | input | 14 | Address bus; carries the mode-register contents |
| rd_valid | output | 1 | Read data returns in this cycle |
| rd_beat | output | 3 | Index of the first of the two beats in this cycle |
| cfg_err | output | 1 | Latency setting illegal for DLL-off mode |
| dll_off | output | 1 | Current mode: 1 = DLL off |

## Verification
All inputs are driven on falling edges, and every output is sampled on a later falling edge. A mode-register write therefore shows up on `dll_off` and `cfg_err` at the first falling edge after its capturing rising edge. A read captured at edge k produces beat 0 at the falling edge that follows edge k + L, where L is the expected latency. The bench counts rising edges from the capturing edge and takes the first valid cycle as the measured latency. It then checks the next three cycles for beats 2, 4 and 6, and checks that the cycle after those is idle. In the overlap and in-flight cases, commands issued during the wait advance the same edge count, so the expected cycle stays fixed.

// File: rtl/rrt_pkg.sv
package rrt_pkg;
  typedef enum logic [2:0] {
    CMD_DESEL,
    CMD_NOP,
    CMD_MRS,
    CMD_READ,
    CMD_OTHER
  } cmd_t;

  function automatic cmd_t decode_cmd(input logic cs_n, input logic ras_n,
                                      input logic cas_n, input logic we_n);
    cmd_t c;
    if (cs_n) c = CMD_DESEL;
    else begin
      case ({ras_n, cas_n, we_n})
        3'b111:  c = CMD_NOP;
        3'b000:  c = CMD_MRS;
        3'b101:  c = CMD_READ;
        default: c = CMD_OTHER;
      endcase
    end
    return c;
  endfunction
endpackage

// File: rtl/rrt_cmd_decode.sv
module rrt_cmd_decode
  import rrt_pkg::*;
#(
  parameter int BA_W = 3
) (
  input  logic            cs_n,
  input  logic            ras_n,
  input  logic            cas_n,
  input  logic            we_n,
  input  logic [BA_W-1:0] ba,
  output logic            is_read,
  output logic            is_mrs,
  output logic [2:0]      mr_sel
);
  cmd_t cmd;

  always_comb begin
    cmd     = decode_cmd(cs_n, ras_n, cas_n, we_n);
    is_read = (cmd == CMD_READ);
    is_mrs  = (cmd == CMD_MRS);
    for (int m = 0; m < 3; m++) begin
      mr_sel[m] = (ba == BA_W'(m));
    end
  end
endmodule

// File: rtl/rrt_mode_regs.sv
module rrt_mode_regs #(
  parameter int ADDR_W  = 14,
  parameter int CL_W    = 3,
  parameter int CWL_W   = 3,
  parameter int CL_BASE = 4,
  parameter int CWL_BASE = 5,
  parameter int DEF_CL  = 6,
  parameter int DEF_CWL = 6,
  parameter int OFF_CL  = 6,
  parameter int OFF_CWL = 6,
  parameter int LAT_W   = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mrs_we,
  input  logic [2:0]        mr_sel,
  input  logic [ADDR_W-1:0] addr,
  output logic [LAT_W-1:0]  rd_lat,
  output logic              dll_off,
  output logic              cfg_err
);
  localparam int CL_LSB  = 4;
  localparam int AL_LSB  = 3;
  localparam int CWL_LSB = 3;
  localparam int DLL_BIT = 0;
  localparam int LAT_MAX = 2 * (CL_BASE + (1 << CL_W) - 1) - 1;
  localparam logic [CL_W-1:0]  DEF_CL_F  = CL_W'(DEF_CL - CL_BASE);
  localparam logic [CWL_W-1:0] DEF_CWL_F = CWL_W'(DEF_CWL - CWL_BASE);
  localparam logic [CL_W-1:0]  OFF_CL_F  = CL_W'(OFF_CL - CL_BASE);
  localparam logic [CWL_W-1:0] OFF_CWL_F = CWL_W'(OFF_CWL - CWL_BASE);

  logic [CL_W-1:0]  cl_f;
  logic [CWL_W-1:0] cwl_f;
  logic [1:0]       al_f;
  logic             dll_q;
  logic [LAT_W-1:0] cl_val, al_val;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cl_f  <= DEF_CL_F;
      cwl_f <= DEF_CWL_F;
      al_f  <= 2'd0;
      dll_q <= 1'b0;
    end else if (mrs_we) begin
      if (mr_sel[0]) cl_f <= addr[CL_LSB +: CL_W];
      if (mr_sel[1]) begin
        al_f  <= addr[AL_LSB +: 2];
        dll_q <= addr[DLL_BIT];
      end
      if (mr_sel[2]) cwl_f <= addr[CWL_LSB +: CWL_W];
    end
  end

  always_comb begin
    cl_val = LAT_W'(CL_BASE) + LAT_W'(cl_f);
    case (al_f)
      2'd1:    al_val = cl_val - LAT_W'(1);
      2'd2:    al_val = cl_val - LAT_W'(2);
      default: al_val = '0;
    endcase
    rd_lat  = al_val + cl_val - LAT_W'(dll_q);
    dll_off = dll_q;
    cfg_err = dll_q && ((cl_f != OFF_CL_F) || (cwl_f != OFF_CWL_F));
  end

  assert_hold_without_mrs_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !mrs_we |=> $stable({cl_f, al_f, cwl_f, dll_q}));

  assert_lat_in_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_lat >= LAT_W'(CL_BASE - 1)) && (rd_lat <= LAT_W'(LAT_MAX)));
endmodule

// File: rtl/rrt_return_line.sv
module rrt_return_line #(
  parameter int LAT_MAX   = 21,
  parameter int LAT_W     = 5,
  parameter int BURST_LEN = 8
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         start,
  input  logic [LAT_W-1:0]             lat,
  output logic                         rd_valid,
  output logic [$clog2(BURST_LEN)-1:0] rd_beat
);
  localparam int BCLK   = BURST_LEN / 2;
  localparam int PH_W   = $clog2(BCLK);
  localparam int BEAT_W = $clog2(BURST_LEN);
  localparam int SLOTS  = LAT_MAX + BCLK;
  localparam int SW     = $clog2(SLOTS + BCLK + 1) + 1;
  localparam logic [BEAT_W-1:0] LAST_BEAT = BEAT_W'(BURST_LEN - 2);

  logic            vld [SLOTS];
  logic [PH_W-1:0] ph  [SLOTS];
  logic [SW-1:0]   lat_ext;

  assign lat_ext = SW'(lat);

  for (genvar i = 0; i < SLOTS; i++) begin : g_slot
    localparam logic [SW-1:0] IDX = SW'(i);
    logic            hit;
    logic            nxt_v;
    logic [PH_W-1:0] nxt_p;

    assign hit = start && (IDX >= lat_ext) && (IDX < lat_ext + SW'(BCLK));

    if (i == SLOTS - 1) begin : g_tail
      assign nxt_v = 1'b0;
      assign nxt_p = '0;
    end else begin : g_body
      assign nxt_v = vld[i+1];
      assign nxt_p = ph[i+1];
    end

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        vld[i] <= 1'b0;
        ph[i]  <= '0;
      end else if (hit) begin
        vld[i] <= 1'b1;
        ph[i]  <= PH_W'(IDX - lat_ext);
      end else begin
        vld[i] <= nxt_v;
        ph[i]  <= nxt_p;
      end
    end
  end

  assign rd_valid = vld[0];
  assign rd_beat  = vld[0] ? {ph[0], 1'b0} : '0;

  assert_burst_opens_at_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !$past(rd_valid)) |-> (rd_beat == '0));

  assert_burst_steps_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && (rd_beat != LAST_BEAT)) |=>
      (rd_valid && ((rd_beat == $past(rd_beat) + BEAT_W'(2)) || (rd_beat == '0))));
endmodule

// File: rtl/rd_return_tracker.sv
module rd_return_tracker #(
  parameter int ADDR_W    = 14,
  parameter int BA_W      = 3,
  parameter int CL_W      = 3,
  parameter int CWL_W     = 3,
  parameter int BURST_LEN = 8
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         cs_n,
  input  logic                         ras_n,
  input  logic                         cas_n,
  input  logic                         we_n,
  input  logic [BA_W-1:0]              ba,
  input  logic [ADDR_W-1:0]            addr,
  output logic                         rd_valid,
  output logic [$clog2(BURST_LEN)-1:0] rd_beat,
  output logic                         cfg_err,
  output logic                         dll_off
);
  localparam int CL_BASE = 4;
  localparam int LAT_MAX = 2 * (CL_BASE + (1 << CL_W) - 1) - 1;
  localparam int LAT_W   = $clog2(LAT_MAX + 1);

  logic            is_read, is_mrs;
  logic [2:0]      mr_sel;
  logic [LAT_W-1:0] rd_lat;

  rrt_cmd_decode #(.BA_W(BA_W)) u_dec (
    .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .ba(ba),
    .is_read(is_read), .is_mrs(is_mrs), .mr_sel(mr_sel)
  );

  rrt_mode_regs #(
    .ADDR_W(ADDR_W), .CL_W(CL_W), .CWL_W(CWL_W), .CL_BASE(CL_BASE),
    .CWL_BASE(5), .DEF_CL(6), .DEF_CWL(6), .OFF_CL(6), .OFF_CWL(6),
    .LAT_W(LAT_W)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .mrs_we(is_mrs), .mr_sel(mr_sel), .addr(addr),
    .rd_lat(rd_lat), .dll_off(dll_off), .cfg_err(cfg_err)
  );

  rrt_return_line #(
    .LAT_MAX(LAT_MAX), .LAT_W(LAT_W), .BURST_LEN(BURST_LEN)
  ) u_line (
    .clk(clk), .rst_n(rst_n), .start(is_read), .lat(rd_lat),
    .rd_valid(rd_valid), .rd_beat(rd_beat)
  );

  assert_deselect_keeps_mode_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |=> ($stable(dll_off) && $stable(cfg_err)));

  assert_err_only_dll_off_R10: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |-> dll_off);
endmodule

// File: tb/rd_return_tracker_bench.sv
module rd_return_tracker_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b0, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
  logic [2:0]  ba = '0;
  logic [13:0] addr = '0;
  logic        rd_valid, cfg_err, dll_off;
  logic [2:0]  rd_beat;
  int checks = 0;
  int failures = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  rd_return_tracker u_rd_return_tracker (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n),
    .we_n(we_n), .ba(ba), .addr(addr), .rd_valid(rd_valid), .rd_beat(rd_beat),
    .cfg_err(cfg_err), .dll_off(dll_off)
  );

  typedef struct packed {
    logic [2:0] cl;
    logic [1:0] al;
    logic       dll;
    logic [2:0] cwl;
    logic [4:0] lat;
    logic       err;
  } vec_t;

  localparam vec_t VEC [10] = '{
    '{3'd2, 2'd0, 1'b0, 3'd1, 5'd6,  1'b0},
    '{3'd2, 2'd0, 1'b1, 3'd1, 5'd5,  1'b0},
    '{3'd3, 2'd0, 1'b0, 3'd1, 5'd7,  1'b0},
    '{3'd3, 2'd0, 1'b1, 3'd1, 5'd6,  1'b1},
    '{3'd2, 2'd1, 1'b0, 3'd1, 5'd11, 1'b0},
    '{3'd2, 2'd2, 1'b1, 3'd1, 5'd9,  1'b0},
    '{3'd7, 2'd1, 1'b0, 3'd1, 5'd21, 1'b0},
    '{3'd1, 2'd0, 1'b1, 3'd1, 5'd4,  1'b1},
    '{3'd2, 2'd0, 1'b1, 3'd2, 5'd5,  1'b1},
    '{3'd2, 2'd3, 1'b0, 3'd1, 5'd6,  1'b0}
  };

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic drive(input logic c, input logic r, input logic a, input logic w,
                       input logic [2:0] b, input logic [13:0] ad);
    cs_n = c; ras_n = r; cas_n = a; we_n = w; ba = b; addr = ad;
    @(negedge clk);
    cs_n = 1'b0; ras_n = 1'b1; cas_n = 1'b1; we_n = 1'b1; ba = '0; addr = '0;
  endtask

  task automatic mrs(input logic [2:0] b, input logic [13:0] ad);
    drive(1'b0, 1'b0, 1'b0, 1'b0, b, ad);
  endtask

  task automatic rd();
    drive(1'b0, 1'b1, 1'b0, 1'b1, 3'd0, 14'd0);
  endtask

  // Called n0 falling edges after the read's capturing edge.
  task automatic measure(input string req, input int exp_lat, input int n0);
    int first = -1;
    for (int n = n0 + 1; n <= 40 && first < 0; n++) begin
      @(negedge clk);
      if (rd_valid) first = n;
    end
    chk({req, " latency"}, first, exp_lat);
    if (first > 0) begin
      for (int b = 0; b < 4; b++) begin
        if (b > 0) @(negedge clk);
        chk("R8 beat", rd_valid ? int'(rd_beat) : -1, 2 * b);
      end
      @(negedge clk);
      chk("R8 burst end", int'(rd_valid), 0);
    end
  endtask

  task automatic set_defaults();
    mrs(3'd0, 14'(2 << 4));
    mrs(3'd2, 14'(1 << 3));
    mrs(3'd1, 14'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R11 reset state
    chk("R11 rd_valid", int'(rd_valid), 0);
    chk("R11 rd_beat", int'(rd_beat), 0);
    chk("R11 dll_off", int'(dll_off), 0);
    chk("R11 cfg_err", int'(cfg_err), 0);
    rd();
    measure("R11 default R6", 6, 0);

    // R3 deselect with read and MRS patterns
    drive(1'b1, 1'b1, 1'b0, 1'b1, 3'd0, 14'd0);
    drive(1'b1, 1'b0, 1'b0, 1'b0, 3'd1, 14'd1);
    begin
      int seen = 0;
      for (int n = 0; n < 30; n++) begin
        @(negedge clk);
        if (rd_valid) seen++;
      end
      chk("R3 deselect no read", seen, 0);
    end
    chk("R3 deselect no mode change", int'(dll_off), 0);

    // R2/R3 reads in flight survive deselect and NOP
    rd();
    drive(1'b1, 1'b0, 1'b0, 1'b0, 3'd1, 14'd1);
    drive(1'b0, 1'b1, 1'b1, 1'b1, 3'd0, 14'h3fff);
    measure("R2 in-flight", 6, 2);
    chk("R2 nop no mode change", int'(dll_off), 0);

    // R1 other pattern starts nothing
    drive(1'b0, 1'b0, 1'b1, 1'b1, 3'd0, 14'd0);
    begin
      int seen = 0;
      for (int n = 0; n < 25; n++) begin
        @(negedge clk);
        if (rd_valid) seen++;
      end
      chk("R1 other cmd no read", seen, 0);
    end

    // R5 ba=3 ignored
    mrs(3'd3, 14'h3fff);
    chk("R5 ba3 dll", int'(dll_off), 0);
    rd();
    measure("R5 ba3 latency", 6, 0);

    // table of settings
    for (int v = 0; v < 10; v++) begin
      mrs(3'd0, 14'(VEC[v].cl) << 4);
      mrs(3'd2, 14'(VEC[v].cwl) << 3);
      mrs(3'd1, (14'(VEC[v].al) << 3) | 14'(VEC[v].dll));
      chk("R4 dll_off", int'(dll_off), int'(VEC[v].dll));
      chk("R10 cfg_err", int'(cfg_err), int'(VEC[v].err));
      rd();
      measure(VEC[v].dll ? "R7" : "R6", int'(VEC[v].lat), 0);
    end
    set_defaults();
    chk("R4 back on", int'(dll_off), 0);
    chk("R10 cleared", int'(cfg_err), 0);

    // R12 latency fixed at issue
    rd();
    mrs(3'd0, 14'(7 << 4));
    measure("R12 old read", 6, 1);
    rd();
    measure("R12 new read", 11, 0);
    set_defaults();

    // R9 two reads four apart
    rd();
    drive(1'b0, 1'b1, 1'b1, 1'b1, 3'd0, 14'd0);
    drive(1'b0, 1'b1, 1'b1, 1'b1, 3'd0, 14'd0);
    drive(1'b0, 1'b1, 1'b1, 1'b1, 3'd0, 14'd0);
    rd();
    for (int n = 5; n <= 14; n++) begin
      @(negedge clk);
      if (n >= 6 && n <= 13)
        chk("R9 seamless beat", rd_valid ? int'(rd_beat) : -1, ((n - 6) % 4) * 2);
      else
        chk("R9 idle", int'(rd_valid), 0);
    end

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule